// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

The bridge puts a bank of small configuration registers behind one 32-bit host word. The host packs four things into that word: a release bit that takes the bank out of reset, a register index, a byte of write data, and a commit bit. The low byte of the same word always shows the live contents of the register that the index currently selects. Reading a register therefore means writing its index and then reading the word. Writing a register means placing the index and the data in the word and then raising the commit bit. Once it has been raised, the commit bit must be lowered again before the next write can take place.

The host interface is a plain single-cycle port with valid, write, offset and data signals. Only one offset maps to the control word. Every register in the bank is also driven on a flat parallel bus, so the logic around the bridge can use the settings directly.

Top module: `cfg_mbox_bridge`

## Requirements
- R1: While `rst_n` is low, every field of the control word and every bank register is zero, so `bus_rdata` reads 0x0000_0000.
- R2: A host write at the control offset loads four fields: release (bit 28), commit (bit 24), index (bits 20:16) and write data (bits 15:8). All four read back at the same positions. Every other bit of the word reads zero, whatever value was written.
- R3: Bits 7:0 of the control word show the bank register chosen by the index field, with no clock edge in between. An index of 25 or higher reads 0x00.
- R4: When the commit bit goes from 0 to 1 and the release bit is 1, the write-data byte is stored into the register chosen by the index field. The stored value is visible one clock after the control word takes the commit bit.
- R5: While the commit bit stays at 1, the bank does not change again, even if the host rewrites the data or index fields.
- R6: While the release bit is 0, all bank registers clear to 0x00 one clock later and commits are blocked. Raising the release bit while the commit bit is already 1 does not count as a commit. The release, commit, index and data fields stay writable and readable while the bank is held.
- R7: A commit to an index above 24 leaves every bank register unchanged.
- R8: A host write to any offset other than the control offset (0) changes nothing, and a read from any such offset returns zero.
- R9: Register k of the bank is driven on `bank_flat[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Host offset; 0 selects the control word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| bank_flat | output | 200 | All bank registers, register k at bits 8k+7:8k |

## Verification
The properties assume a synchronous host. Inputs change only between clock edges, and any write at the control offset is a full 32-bit word. The commit-once and clear properties rely on the commit and release bits being sampled as register state, never as raw bus bits. The stimulus always writes whole words at the falling edge and holds each access for exactly one cycle. It reaches the corner cases only through the host port: raising the commit bit twice, rewriting the data while the commit bit is held high, and releasing the bank while the commit bit is already high.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   // Control word layout; neighbouring software decodes these positions.
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned RD_LSB     = 0;
   localparam int unsigned WD_LSB     = 8;
   localparam int unsigned IDX_LSB    = 16;
   localparam int unsigned COMMIT_BIT = 24;
   localparam int unsigned REL_BIT    = 28;
endpackage

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
   import cfgb_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic              rel_o,
   output logic              commit_o,
   output logic [AW-1:0]     idx_o,
   output logic [DW-1:0]     wd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_o    <= 1'b0;
         commit_o <= 1'b0;
         idx_o    <= '0;
         wd_o     <= '0;
      end else if (ld_i) begin
         rel_o    <= wdata_i[REL_BIT];
         commit_o <= wdata_i[COMMIT_BIT];
         idx_o    <= wdata_i[IDX_LSB +: AW];
         wd_o     <= wdata_i[WD_LSB +: DW];
      end
   end

   // R2: loaded fields follow the written word
   p_fields_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (rel_o == $past(wdata_i[REL_BIT])) &&
               (commit_o == $past(wdata_i[COMMIT_BIT])) &&
               (idx_o == $past(wdata_i[IDX_LSB +: AW])));

   // R8: no load, no change
   p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> $stable(idx_o) && $stable(wd_o) && $stable(rel_o));
endmodule

// File: rtl/cfgb_commit.sv
module cfgb_commit (
   input  logic clk,
   input  logic rst_n,
   input  logic commit_i,
   input  logic rel_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= commit_i;
   end

   assign pulse_o = commit_i & ~prev_q & rel_i;

   // R5: a held commit bit produces a single strobe
   p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

   // R6: a strobe needs the commit bit to have been low a cycle earlier
   p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit_i) |-> !pulse_o);
endmodule

// File: rtl/cfgb_bank.sv
module cfgb_bank #(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 5,
   parameter int unsigned NUM_REGS = 25,
   localparam int unsigned FLAT_W  = NUM_REGS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rel_i,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_idx_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic [AW-1:0]     rd_idx_i,
   output logic [DW-1:0]     rd_data_o,
   output logic [FLAT_W-1:0] flat_o
);
   logic [DW-1:0] regs [NUM_REGS];
   logic          rd_in_range;
   logic [DW-1:0] rd_mux;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     regs[k] <= '0;
         else if (!rel_i)                                regs[k] <= '0;
         else if (wr_en_i && (wr_idx_i == AW'(k)))       regs[k] <= wr_data_i;
      end
      assign flat_o[k*DW +: DW] = regs[k];
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_idx_i == AW'(k)) rd_mux = regs[k];
   end

   if (NUM_REGS < (1 << AW)) begin : g_partial
      assign rd_in_range = (int'(rd_idx_i) < NUM_REGS);
   end else begin : g_full
      assign rd_in_range = 1'b1;
   end

   assign rd_data_o = rd_in_range ? rd_mux : '0;

   // R4: a strobe to a valid index lands the data one edge later
   p_commit_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && rel_i && (int'(wr_idx_i) < NUM_REGS)) |=>
         (regs[$past(wr_idx_i)] == $past(wr_data_i)));

   // R6: holding the bank clears it
   p_hold_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_i |=> (flat_o == '0));

   // R7: nothing moves without a strobe to a valid index
   p_no_stray_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_i && !(wr_en_i && (int'(wr_idx_i) < NUM_REGS))) |=> $stable(flat_o));
endmodule

// File: rtl/cfg_mbox_bridge.sv
module cfg_mbox_bridge
   import cfgb_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 5,
   parameter int unsigned NUM_REGS = 25,
   parameter int unsigned BUS_AW   = 4,
   parameter int unsigned CTRL_OFS = 0,
   localparam int unsigned FLAT_W  = NUM_REGS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [FLAT_W-1:0] bank_flat
);
   if (NUM_REGS > (1 << AW)) begin : g_chk_depth
      $error("bank depth exceeds index range");
   end
   if ((RD_LSB + DW > WD_LSB) || (WD_LSB + DW > IDX_LSB) ||
       (IDX_LSB + AW > COMMIT_BIT)) begin : g_chk_layout
      $error("control word fields overlap");
   end

   logic          hit, ld;
   logic          rel, commit, strobe;
   logic [AW-1:0] idx;
   logic [DW-1:0] wd, rd;
   logic [31:0]   word;

   assign hit = (bus_addr == BUS_AW'(CTRL_OFS));
   assign ld  = bus_valid & bus_write & hit;

   cfgb_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ld_i(ld), .wdata_i(bus_wdata),
      .rel_o(rel), .commit_o(commit), .idx_o(idx), .wd_o(wd)
   );

   cfgb_commit u_commit (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .rel_i(rel), .pulse_o(strobe)
   );

   cfgb_bank #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n), .rel_i(rel), .wr_en_i(strobe),
      .wr_idx_i(idx), .wr_data_i(wd), .rd_idx_i(idx), .rd_data_o(rd),
      .flat_o(bank_flat)
   );

   always_comb begin
      word                  = '0;
      word[REL_BIT]         = rel;
      word[COMMIT_BIT]      = commit;
      word[IDX_LSB +: AW]   = idx;
      word[WD_LSB +: DW]    = wd;
      word[RD_LSB +: DW]    = rd;
   end

   assign bus_rdata = hit ? word : '0;

   // R8: other offsets read zero
   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (bus_rdata == '0));

   // R3: the low byte tracks the bank bus for the selected index
   p_live_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (int'(idx) < NUM_REGS)) |-> (bus_rdata[RD_LSB +: DW] == bank_flat[idx*DW +: DW]));
endmodule

// File: tb/tb_cfg_mbox_bridge.sv
module tb_cfg_mbox_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 25;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_valid = 1'b0, bus_write = 1'b0;
   logic [3:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [NREG*8-1:0] bank_flat;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [7:0] exp_bank [NREG];

   // index, data
   localparam logic [12:0] VEC [6] = '{
      {5'd0, 8'hA5}, {5'd1, 8'h5A}, {5'd7, 8'hFF},
      {5'd12, 8'h01}, {5'd23, 8'h80}, {5'd24, 8'hC7}};

   cfg_mbox_bridge dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bank_flat(bank_flat));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] cw(bit rel, bit com, logic [4:0] idx, logic [7:0] d);
      return {3'b0, rel, 3'b0, com, 3'b0, idx, d, 8'h00};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bank(string req);
      for (int k = 0; k < NREG; k++) begin
         checks++;
         if (bank_flat[k*8 +: 8] !== exp_bank[k]) begin
            errors++;
            $display("FAIL %s: reg %0d actual=%h expected=%h", req, k, bank_flat[k*8 +: 8], exp_bank[k]);
         end
      end
   endtask

   task automatic bwr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
   endtask

   task automatic rd_word(logic [3:0] a, output logic [31:0] v);
      bus_addr = a; #1; v = bus_rdata; bus_addr = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(logic [4:0] idx, logic [7:0] d);
      bwr(4'd0, cw(1, 0, idx, d));
      bwr(4'd0, cw(1, 1, idx, d));
      bwr(4'd0, cw(1, 0, idx, d));
      if (idx < NREG) exp_bank[idx] = d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      for (int k = 0; k < NREG; k++) exp_bank[k] = 8'h00;
      idle(3);
      // R1: reset state
      rd_word(4'd0, v); chk("R1 word in reset", v, 32'h0);
      chk_bank("R1 bank in reset");
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      rd_word(4'd0, v); chk("R1 word after reset", v, 32'h0);

      // R4, R3, R9: table walk
      for (int i = 0; i < 6; i++) begin
         reg_write(VEC[i][12:8], VEC[i][7:0]);
         rd_word(4'd0, v);
         chk("R3 live read", {24'h0, v[7:0]}, {24'h0, VEC[i][7:0]});
         chk("R4 stored", {24'h0, bank_flat[VEC[i][12:8]*8 +: 8]}, {24'h0, VEC[i][7:0]});
      end
      chk_bank("R9 flat bus after table");

      // R3: change index only, no strobe
      bwr(4'd0, cw(1, 0, 5'd7, 8'h00));
      rd_word(4'd0, v); chk("R3 reselect", v, 32'h1007_00FF);
      // R3: out-of-range index reads zero
      bwr(4'd0, cw(1, 0, 5'd30, 8'h11));
      rd_word(4'd0, v); chk("R3 index 30 reads zero", v, 32'h101E_1100);

      // R7: commit to index 31 ignored
      reg_write(5'd31, 8'hEE);
      idle(1);
      chk_bank("R7 out-of-range commit");

      // R2: all ones written
      bwr(4'd0, 32'hFFFF_FFFF);
      rd_word(4'd0, v); chk("R2 field readback", v, 32'h111F_FF00);
      idle(2);
      chk_bank("R7 all-ones commit ignored");
      bwr(4'd0, cw(1, 0, 5'd3, 8'h00));

      // R5: held commit writes once
      bwr(4'd0, cw(1, 1, 5'd3, 8'h3C));
      idle(1); exp_bank[3] = 8'h3C;
      chk_bank("R5 first commit");
      bwr(4'd0, cw(1, 1, 5'd3, 8'hC3));
      idle(2);
      chk_bank("R5 held commit");
      rd_word(4'd0, v); chk("R5 readback", v, 32'h1103_C33C);
      bwr(4'd0, cw(1, 1, 5'd4, 8'h44));
      idle(2);
      chk_bank("R5 index change while held");
      bwr(4'd0, cw(1, 0, 5'd4, 8'h44));

      // R8: other offsets
      bwr(4'd4, 32'hFFFF_FFFF);
      rd_word(4'd4, v); chk("R8 other offset reads zero", v, 32'h0);
      rd_word(4'd0, v); chk("R8 control word untouched", v, 32'h1004_4400);
      idle(1); chk_bank("R8 bank untouched");

      // R6: hold bank
      bwr(4'd0, cw(0, 0, 5'd5, 8'h99));
      idle(1);
      for (int k = 0; k < NREG; k++) exp_bank[k] = 8'h00;
      chk_bank("R6 clear on hold");
      rd_word(4'd0, v); chk("R6 fields while held", v, 32'h0005_9900);
      bwr(4'd0, cw(0, 1, 5'd5, 8'h99));
      idle(2); chk_bank("R6 commit blocked");
      bwr(4'd0, cw(1, 1, 5'd5, 8'h99));
      idle(2); chk_bank("R6 release with commit high");
      rd_word(4'd0, v); chk("R6 release readback", v, 32'h1105_9900);

      // R1: reset again mid-run
      reg_write(5'd9, 8'h77);
      idle(1);
      @(negedge clk); rst_n = 1'b0; #1;
      for (int k = 0; k < NREG; k++) exp_bank[k] = 8'h00;
      rd_word(4'd0, v); chk("R1 second reset", v, 32'h0);
      chk_bank("R1 bank second reset");
      idle(2);
      finish_run();
   end
endmodule